// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Flags

This block adds, subtracts, increments, decrements or passes through byte operands. It computes the result combinationally in the same cycle as its operands. The flags for that result are captured in an 8-bit status register on the next rising clock edge. The flags are carry, zero, negative, two's-complement overflow, sign and half-carry. The carry and half-carry flags follow the borrow convention on subtraction.

Bits 7 and 6 of the status register hold an interrupt-enable bit and a transfer bit. The arithmetic never changes them. A full-register write port can load all eight bits at once. That write wins over a flag update in the same cycle. Any surrounding control logic uses the port to save and restore the flags.

The status bit layout from bit 7 down to bit 0 is: interrupt-enable, transfer, half-carry (H), sign (S), overflow (V), negative (N), zero (Z), carry (C).

Top module: `alu_status_unit`

## Requirements
- R1: `res` follows the operation code in the same cycle, modulo 256. Code 0 gives `opa+opb`. Code 1 gives `opa-opb`. Code 2 gives `opa+1`. Code 3 gives `opa-1`. Codes 4 to 7 give `opb`.
- R2: On add (code 0), status bit 0 (C) becomes the carry out of bit 7 and status bit 5 (H) becomes the carry from bit 3 into bit 4. Examples: 0x38+0x2F gives 0x67 with C=0, H=1, Z=0. 0x9C+0x64 gives 0x00 with C=1, H=1, Z=1.
- R3: On subtract (code 1), C is set when `opb` is larger than `opa`, and H is set when the low nibble of `opb` is larger than the low nibble of `opa`. Examples: 0x52-0x73 gives 0xDF with C=1, H=1. 0xA5-0x23 gives 0x82 with C=0, H=0. 0x9C-0x9C gives 0x00 with C=0, H=0, Z=1.
- R4: On a flag update, status bit 1 (Z) is set exactly when `res` is zero, and status bit 2 (N) copies bit 7 of `res`.
- R5: Status bit 3 (V) is set when the signed add or subtract result falls outside -128..127.
- R6: After every flag update, status bit 4 (S) equals N xor V.
- R7: Increment and decrement leave C and H unchanged. V is set only when incrementing 0x7F or decrementing 0x80.
- R8: Pass-through (codes 4 to 7) clears V, leaves C and H unchanged, and sets Z and N from `opb`.
- R9: Flags change only on an edge where `flag_en` is 1. Bits 7 and 6 are never changed by a flag update.
- R10: When `sreg_wr` is 1, the next status value is `sreg_wdata`, whatever `flag_en` is.
- R11: A synchronous active-high `rst` clears all eight status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | WIDTH | First operand (minuend, increment/decrement source) |
| opb | input | WIDTH | Second operand (addend, subtrahend, pass-through source) |
| op | input | 3 | Operation code |
| flag_en | input | 1 | Capture the flags of the current operation |
| sreg_wr | input | 1 | Load the whole status register |
| sreg_wdata | input | 8 | Value for a whole-register load |
| res | output | WIDTH | Combinational result |
| sreg | output | 8 | Status register |

## Verification
The bench builds the unit with WIDTH left at 8. With that width the byte boundaries are reachable by direct stimulus: 0x7F and 0x80 for overflow, 0xFF for wrap, and the nibble edge at bit 3 for half-carry. It also covers the worked add and subtract examples with their expected flags. Random operands and codes, together with random update, write and write-data values, reach every pairing of flag update against full-register write.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

  localparam int SREG_W = 8;

  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_N = 2;
  localparam int B_V = 3;
  localparam int B_S = 4;
  localparam int B_H = 5;
  localparam int B_T = 6;
  localparam int B_I = 7;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_PASS = 3'd4
  } alu_op_e;

endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_status_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] res,
  output logic             c_flag,
  output logic             h_flag,
  output logic             v_flag,
  output logic             cy_upd
);
  localparam int HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH:0] wide;
  logic [HALF:0]  nib;

  always_comb begin
    wide   = '0;
    nib    = '0;
    res    = b;
    c_flag = 1'b0;
    h_flag = 1'b0;
    v_flag = 1'b0;
    cy_upd = 1'b0;
    case (alu_op_e'(op))
      OP_ADD: begin
        wide   = {1'b0, a} + {1'b0, b};
        nib    = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]};
        res    = wide[WIDTH-1:0];
        c_flag = wide[WIDTH];
        h_flag = nib[HALF];
        v_flag = (a[WIDTH-1] ~^ b[WIDTH-1]) & (wide[WIDTH-1] ^ a[WIDTH-1]);
        cy_upd = 1'b1;
      end
      OP_SUB: begin
        wide   = {1'b0, a} - {1'b0, b};
        nib    = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]};
        res    = wide[WIDTH-1:0];
        c_flag = wide[WIDTH];
        h_flag = nib[HALF];
        v_flag = (a[WIDTH-1] ^ b[WIDTH-1]) & (wide[WIDTH-1] ^ a[WIDTH-1]);
        cy_upd = 1'b1;
      end
      OP_INC: begin
        res    = a + ONE;
        v_flag = ~a[WIDTH-1] & res[WIDTH-1];
      end
      OP_DEC: begin
        res    = a - ONE;
        v_flag = a[WIDTH-1] & ~res[WIDTH-1];
      end
      default: begin
        res    = b;
        v_flag = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] res,
  input  logic             v_flag,
  output logic             z_flag,
  output logic             n_flag,
  output logic             s_flag
);
  always_comb begin
    z_flag = (res == '0);
    n_flag = res[WIDTH-1];
    s_flag = n_flag ^ v_flag;
  end
endmodule

// File: rtl/alu_sreg_reg.sv
module alu_sreg_reg
  import alu_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [SREG_W-1:0] wdata,
  input  logic              upd,
  input  logic              cy_upd,
  input  logic              c_flag,
  input  logic              h_flag,
  input  logic              v_flag,
  input  logic              z_flag,
  input  logic              n_flag,
  input  logic              s_flag,
  output logic [SREG_W-1:0] sreg
);
  logic [SREG_W-1:0] nxt;

  always_comb begin
    nxt = sreg;
    if (wr) begin
      nxt = wdata;
    end else if (upd) begin
      nxt[B_Z] = z_flag;
      nxt[B_N] = n_flag;
      nxt[B_V] = v_flag;
      nxt[B_S] = s_flag;
      if (cy_upd) begin
        nxt[B_C] = c_flag;
        nxt[B_H] = h_flag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else     sreg <= nxt;
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [2:0]        op,
  input  logic              flag_en,
  input  logic              sreg_wr,
  input  logic [SREG_W-1:0] sreg_wdata,
  output logic [WIDTH-1:0]  res,
  output logic [SREG_W-1:0] sreg
);
  logic c_f, h_f, v_f, z_f, n_f, s_f, cy_f;

  alu_arith_core #(.WIDTH(WIDTH)) u_core (
    .a(opa), .b(opb), .op(op), .res(res),
    .c_flag(c_f), .h_flag(h_f), .v_flag(v_f), .cy_upd(cy_f)
  );

  alu_flag_eval #(.WIDTH(WIDTH)) u_eval (
    .res(res), .v_flag(v_f), .z_flag(z_f), .n_flag(n_f), .s_flag(s_f)
  );

  alu_sreg_reg u_sreg (
    .clk(clk), .rst(rst), .wr(sreg_wr), .wdata(sreg_wdata),
    .upd(flag_en), .cy_upd(cy_f),
    .c_flag(c_f), .h_flag(h_f), .v_flag(v_f),
    .z_flag(z_f), .n_flag(n_f), .s_flag(s_f),
    .sreg(sreg)
  );
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op,
  input logic             flag_en,
  input logic             sreg_wr,
  input logic [7:0]       sreg_wdata,
  input logic [WIDTH-1:0] res,
  input logic [7:0]       sreg
);
  // R10
  wr_priority_chk: assert property (@(posedge clk) disable iff (rst)
    sreg_wr |=> sreg == $past(sreg_wdata));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sreg_wr && !flag_en) |=> $stable(sreg));

  // R9
  keep_it_chk: assert property (@(posedge clk) disable iff (rst)
    (!sreg_wr && flag_en) |=> sreg[7:6] == $past(sreg[7:6]));

  // R6
  sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (!sreg_wr && flag_en) |=> sreg[4] == (sreg[2] ^ sreg[3]));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!sreg_wr && flag_en) |=> sreg[1] == ($past(res) == '0));

  // R7
  incdec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!sreg_wr && flag_en && (op == 3'd2 || op == 3'd3))
      |=> (sreg[0] == $past(sreg[0])) && (sreg[5] == $past(sreg[5])));
endmodule

bind alu_status_unit alu_status_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op(op), .flag_en(flag_en), .sreg_wr(sreg_wr),
  .sreg_wdata(sreg_wdata), .res(res), .sreg(sreg)
);

// File: tb/alu_status_unit_bench.sv
module alu_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opa = '0, opb = '0, sreg_wdata = '0;
  logic [2:0] op = '0;
  logic       flag_en = 1'b0, sreg_wr = 1'b0;
  logic [7:0] res, sreg;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_sreg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_status_unit #(.WIDTH(8)) u_alu_status_unit (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op(op),
    .flag_en(flag_en), .sreg_wr(sreg_wr), .sreg_wdata(sreg_wdata),
    .res(res), .sreg(sreg)
  );

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic logic [7:0] exp_res(input int a, input int b, input int o);
    int r;
    case (o)
      0: r = a + b;
      1: r = a - b;
      2: r = a + 1;
      3: r = a - 1;
      default: r = b;
    endcase
    return 8'(r & 255);
  endfunction

  function automatic logic [7:0] exp_next(input int a, input int b, input int o,
      input logic fe, input logic wr, input logic [7:0] wd, input logic [7:0] cur);
    logic [7:0] n;
    int r, sv;
    logic v;
    n = cur;
    if (wr) return wd;
    if (!fe) return cur;
    r = int'(exp_res(a, b, o));
    case (o)
      0: begin
        n[0] = (a + b) > 255;
        n[5] = ((a & 15) + (b & 15)) > 15;
        sv = sgn(a) + sgn(b); v = (sv > 127) || (sv < -128);
      end
      1: begin
        n[0] = b > a;
        n[5] = (b & 15) > (a & 15);
        sv = sgn(a) - sgn(b); v = (sv > 127) || (sv < -128);
      end
      2: v = (a == 127);
      3: v = (a == 128);
      default: v = 1'b0;
    endcase
    n[1] = (r == 0);
    n[2] = (r > 127);
    n[3] = v;
    n[4] = n[2] ^ v;
    return n;
  endfunction

  // drive at negedge, check res combinationally, check sreg at the next negedge
  task automatic step(input int a, input int b, input int o, input logic fe,
      input logic wr, input logic [7:0] wd, input string tag);
    logic [7:0] er;
    opa = 8'(a); opb = 8'(b); op = 3'(o);
    flag_en = fe; sreg_wr = wr; sreg_wdata = wd;
    #1;
    er = exp_res(a, b, o);
    chk(res == er, {tag, " res"}, res, er);
    exp_sreg = exp_next(a, b, o, fe, wr, wd, exp_sreg);
    @(posedge clk);
    @(negedge clk);
    chk(sreg == exp_sreg, {tag, " sreg"}, sreg, exp_sreg);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sreg == 8'h00, "R11 reset", sreg, 8'h00);
    rst = 1'b0;

    // R2 worked additions
    step(8'h38, 8'h2F, 0, 1, 0, 8'h00, "R2 add 38+2F");
    chk(sreg[0] == 0 && sreg[5] == 1 && sreg[1] == 0, "R2 C/H/Z", sreg, exp_sreg);
    step(8'h9C, 8'h64, 0, 1, 0, 8'h00, "R2 add 9C+64");
    // R3 worked subtractions
    step(8'h52, 8'h73, 1, 1, 0, 8'h00, "R3 sub 52-73");
    chk(sreg[0] == 1 && sreg[5] == 1, "R3 borrow", sreg, exp_sreg);
    step(8'hA5, 8'h23, 1, 1, 0, 8'h00, "R3 sub A5-23");
    step(8'h9C, 8'h9C, 1, 1, 0, 8'h00, "R3 R4 sub equal");
    // R5 signed overflow
    step(8'h70, 8'h10, 0, 1, 0, 8'h00, "R5 add overflow");
    step(8'h80, 8'h01, 1, 1, 0, 8'h00, "R5 sub overflow");
    // R7 inc/dec: set C,H first, then check they survive
    step(8'hFF, 8'h01, 0, 1, 0, 8'h00, "R2 set C H");
    step(8'h7F, 8'h00, 2, 1, 0, 8'h00, "R7 inc 7F");
    chk(sreg[3] == 1 && sreg[0] == 1 && sreg[5] == 1, "R7 inc flags", sreg, exp_sreg);
    step(8'h80, 8'h00, 3, 1, 0, 8'h00, "R7 dec 80");
    step(8'hFF, 8'h00, 2, 1, 0, 8'h00, "R7 inc FF");
    step(8'h00, 8'h00, 3, 1, 0, 8'h00, "R7 dec 00");
    // R8 pass-through
    step(8'h12, 8'h80, 4, 1, 0, 8'h00, "R8 pass 80");
    step(8'h12, 8'h00, 7, 1, 0, 8'h00, "R8 pass 00 code7");
    // R9 no update when flag_en low
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R9 hold");
    // R10 write wins, then R9 keeps I and T
    step(8'h01, 8'h01, 0, 1, 1, 8'hC0, "R10 write priority");
    step(8'h01, 8'h01, 0, 1, 0, 8'h00, "R9 keep I T");
    chk(sreg[7:6] == 2'b11, "R9 I T kept", sreg, exp_sreg);
    step(8'h00, 8'h00, 0, 0, 1, 8'h3F, "R10 write no update");

    // random mix (R1 R6 R9 R10)
    for (int i = 0; i < 400; i++) begin
      int ra, rb, ro;
      logic rfe, rwr;
      ra = int'($urandom_range(0, 255));
      rb = int'($urandom_range(0, 255));
      ro = int'($urandom_range(0, 7));
      rfe = ($urandom_range(0, 3) != 0);
      rwr = ($urandom_range(0, 7) == 0);
      step(ra, rb, ro, rfe, rwr, 8'($urandom_range(0, 255)), "R1 R6 random");
    end

    // R11 reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(sreg == 8'h00, "R11 reset again", sreg, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule